// File: doc/BRIEF.md
# Serial Gain and Level Control Register Port

This block is the slave side of a three-wire serial control port that sits in front of a small register file for a two-channel volume stage. The bus master pulls an active-low select low and clocks in a 16-bit word on the serial clock. The first byte names a register and says whether the access is a read or a write. The second byte is either the value to store or, on a read, the register contents, which the block shifts back on the same data wire. The shared data wire appears here as a separate input, output and output-enable, and the pad combines them. The output-enable is raised only while a read returns its data byte, so several ports can share one clock line and one data line.

A system clock much faster than the serial clock oversamples the serial select, clock and data. Each goes through a two-stage synchronizer, and the block then detects edges. A frame-control state machine has the states IDLE, ADDR, WDATA, COMMIT, RDATA, RTAIL and HOLD. IDLE goes to ADDR when select goes low. ADDR goes to WDATA or RDATA after the eighth rising edge, chosen by the read/write flag. WDATA goes to COMMIT on the sixteenth rising edge. COMMIT always goes on to HOLD. RDATA goes to RTAIL on the sixteenth rising edge, and RTAIL goes to HOLD on the next falling edge. Every state except COMMIT returns to IDLE when select goes high.

The register file holds two gain registers, a peak-reference register, a test register and a two-bit overload status. Neighbouring logic receives one-cycle write strobes for the gains and a one-cycle pulse when the status register is read. The overload comparators set the status flags.

Top module: `svc_regport`

## Requirements
- R1: Bits are taken on rising serial-clock edges while select is low, MSB first. Address byte bits 6:3 hold the register address and bit 2 is the access flag (1 read, 0 write). Bits 7, 1 and 0 are ignored.
- R2: Address 1101 is the left gain, 1110 the right gain, 1100 the peak reference and 1010 the test register. A written value reads back unchanged.
- R3: A write to address 1111 loads the same byte into both gains and pulses both gain strobes in the same cycle. A read of 1111 returns 0x00.
- R4: On a read, the data byte is driven MSB first. Each bit changes only after a falling serial-clock edge, and the output-enable is high only during the data byte of a read.
- R5: The output-enable is low whenever select has been high for three system clocks.
- R6: After reset, both gains, the test register and the status read 0x00, and the peak reference reads 0xFF.
- R7: Status bit 1 is the left overload flag and bit 0 is the right overload flag. Each flag stays set until a status read (address 1011), which returns the flags and clears them. A set in the clearing cycle wins.
- R8: Each gain strobe is a one-cycle pulse that rises with the new gain value on the port. A status read gives exactly one one-cycle pulse on `status_rd`.
- R9: A frame closed before its sixteenth bit changes no register. Bits after the sixteenth are ignored.
- R10: Test register bit 1 drives `mute_oe` and bits 4:2 drive `mute_sel`.
- R11: Writes to the status address or to unassigned addresses change nothing. Reads of unassigned addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the master |
| sdata_in | input | 1 | Serial data wire, input side |
| sdata_out | output | 1 | Serial data wire, output side |
| sdata_oe | output | 1 | Drive enable for the serial data wire |
| ovl_left_set | input | 1 | Left overload comparator pulse |
| ovl_right_set | input | 1 | Right overload comparator pulse |
| gain_left | output | 8 | Left gain code |
| gain_right | output | 8 | Right gain code |
| gain_left_wr | output | 1 | One-cycle strobe on a left gain write |
| gain_right_wr | output | 1 | One-cycle strobe on a right gain write |
| peak_ref | output | 8 | Peak detector reference code |
| status_rd | output | 1 | One-cycle pulse on a status read |
| mute_oe | output | 1 | Mute pin drive enable from the test register |
| mute_sel | output | 3 | Mute pin observation select |

## Verification
A wrong frame state or bit count shows on the serial wire within the same word. Data comes back shifted, or the output-enable rises during the address byte or stays high after select goes high. A register that is decoded wrongly or loaded spuriously only shows up at the next read of that address or on the gain ports and strobes. Each write is therefore followed by a read, and the strobes and status pulses are counted. A status flag that fails to stick or fails to clear is exposed by reading the status twice in a row.

// File: rtl/svc_pkg.sv
package svc_pkg;
    localparam int DW = 8;
    localparam int AW = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_COMMIT,
        ST_RDATA,
        ST_RTAIL,
        ST_HOLD
    } svc_state_e;

    localparam logic [AW-1:0] ADR_TEST   = 4'hA;
    localparam logic [AW-1:0] ADR_STATUS = 4'hB;
    localparam logic [AW-1:0] ADR_REF    = 4'hC;
    localparam logic [AW-1:0] ADR_GAIN_L = 4'hD;
    localparam logic [AW-1:0] ADR_GAIN_R = 4'hE;
    localparam logic [AW-1:0] ADR_BOTH   = 4'hF;
endpackage

// File: rtl/svc_sync_edge.sv
module svc_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {PW{RST_VAL}};
        end else begin
            pipe_q <= {pipe_q[PW-2:0], d_i};
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/svc_frame_fsm.sv
module svc_frame_fsm
    import svc_pkg::*;
#(
    parameter int DW     = svc_pkg::DW,
    parameter int AW     = svc_pkg::AW,
    parameter int RW_BIT = 2,
    parameter int A_LSB  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_lvl,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          sd_bit,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          sdo,
    output logic          sdo_oe
);
    localparam int FRAME = 2 * DW;
    localparam int CW    = $clog2(FRAME);
    localparam logic [CW-1:0] ADDR_LAST = CW'(DW - 1);
    localparam logic [CW-1:0] DATA_LAST = CW'(FRAME - 1);

    svc_state_e state_q, state_d;

    logic [CW-1:0] cnt_q;
    logic [DW-1:0] rx_q;
    logic [DW-1:0] tx_q;
    logic [AW-1:0] addr_q;
    logic          sdo_q;
    logic          oe_q;
    logic [DW-1:0] byte_now;
    logic          addr_done;
    logic          last_rise;
    logic          shifting;

    assign byte_now  = {rx_q[DW-2:0], sd_bit};
    assign addr_done = (state_q == ST_ADDR) && sck_rise && (cnt_q == ADDR_LAST);
    assign last_rise = sck_rise && (cnt_q == DATA_LAST);
    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_WDATA) || (state_q == ST_RDATA);

    assign rd_addr = byte_now[A_LSB +: AW];
    assign rd_req  = addr_done && byte_now[RW_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_lvl) state_d = ST_ADDR;
            ST_ADDR:   if (addr_done) state_d = byte_now[RW_BIT] ? ST_RDATA : ST_WDATA;
            ST_WDATA:  if (last_rise) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_HOLD;
            ST_RDATA:  if (last_rise) state_d = ST_RTAIL;
            ST_RTAIL:  if (sck_fall) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_HOLD;
            default:   state_d = ST_IDLE;
        endcase
        if (cs_lvl && (state_q != ST_IDLE) && (state_q != ST_COMMIT)) begin
            state_d = ST_IDLE;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '0;
            addr_q <= '0;
            sdo_q  <= 1'b0;
            oe_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                cnt_q <= '0;
                rx_q  <= '0;
            end else if (sck_rise && shifting) begin
                cnt_q <= cnt_q + 1'b1;
                rx_q  <= byte_now;
            end
            if (addr_done) begin
                addr_q <= rd_addr;
                if (byte_now[RW_BIT]) begin
                    tx_q <= rd_data;
                end
            end
            if ((state_q == ST_RDATA) && sck_fall) begin
                sdo_q <= tx_q[DW-1];
                tx_q  <= {tx_q[DW-2:0], 1'b0};
                oe_q  <= 1'b1;
            end
            if ((state_q == ST_RTAIL) && sck_fall) begin
                oe_q <= 1'b0;
            end
            if (cs_lvl) begin
                oe_q <= 1'b0;
            end
        end
    end

    assign wr_en   = (state_q == ST_COMMIT);
    assign wr_addr = addr_q;
    assign wr_data = rx_q;
    assign sdo     = sdo_q;
    assign sdo_oe  = oe_q;
endmodule

// File: rtl/svc_regfile.sv
module svc_regfile
    import svc_pkg::*;
#(
    parameter int            DW      = svc_pkg::DW,
    parameter int            AW      = svc_pkg::AW,
    parameter logic [DW-1:0] REF_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    input  logic          set_left,
    input  logic          set_right,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] gain_l,
    output logic [DW-1:0] gain_r,
    output logic [DW-1:0] ref_q,
    output logic [DW-1:0] test_q,
    output logic          gain_l_wr,
    output logic          gain_r_wr,
    output logic          stat_rd
);
    localparam int SW = 2;

    logic [SW-1:0] stat_q;
    logic          stat_clr;

    assign stat_clr = rd_req && (rd_addr == ADR_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_l    <= '0;
            gain_r    <= '0;
            ref_q     <= REF_RST;
            test_q    <= '0;
            gain_l_wr <= 1'b0;
            gain_r_wr <= 1'b0;
        end else begin
            gain_l_wr <= 1'b0;
            gain_r_wr <= 1'b0;
            if (wr_en) begin
                case (wr_addr)
                    ADR_GAIN_L: begin
                        gain_l    <= wr_data;
                        gain_l_wr <= 1'b1;
                    end
                    ADR_GAIN_R: begin
                        gain_r    <= wr_data;
                        gain_r_wr <= 1'b1;
                    end
                    ADR_BOTH: begin
                        gain_l    <= wr_data;
                        gain_r    <= wr_data;
                        gain_l_wr <= 1'b1;
                        gain_r_wr <= 1'b1;
                    end
                    ADR_REF:  ref_q  <= wr_data;
                    ADR_TEST: test_q <= wr_data;
                    default:  ;
                endcase
            end
        end
    end

    // overload flags: sticky, cleared by a status read, a new set wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q  <= '0;
            stat_rd <= 1'b0;
        end else begin
            stat_q  <= (stat_clr ? '0 : stat_q) | {set_left, set_right};
            stat_rd <= stat_clr;
        end
    end

    always_comb begin
        case (rd_addr)
            ADR_GAIN_L: rd_data = gain_l;
            ADR_GAIN_R: rd_data = gain_r;
            ADR_REF:    rd_data = ref_q;
            ADR_TEST:   rd_data = test_q;
            ADR_STATUS: rd_data = {{(DW-SW){1'b0}}, stat_q};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/svc_regport.sv
module svc_regport
    import svc_pkg::*;
#(
    parameter int            DW       = svc_pkg::DW,
    parameter int            AW       = svc_pkg::AW,
    parameter int            SYNC     = 2,
    parameter logic [DW-1:0] REF_RST  = '1,
    parameter int            MOE_BIT  = 1,
    parameter int            MSEL_LSB = 2,
    parameter int            MSEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdata_in,
    output logic              sdata_out,
    output logic              sdata_oe,
    input  logic              ovl_left_set,
    input  logic              ovl_right_set,
    output logic [DW-1:0]     gain_left,
    output logic [DW-1:0]     gain_right,
    output logic              gain_left_wr,
    output logic              gain_right_wr,
    output logic [DW-1:0]     peak_ref,
    output logic              status_rd,
    output logic              mute_oe,
    output logic [MSEL_W-1:0] mute_sel
);
    logic          cs_lvl, cs_rise, cs_fall;
    logic          sck_lvl, sck_rise, sck_fall;
    logic          sd_lvl, sd_rise, sd_fall;
    logic          rd_req, wr_en;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] rd_data, wr_data, test_q;
    logic          unused_sync;

    svc_sync_edge #(.STAGES(SYNC), .RST_VAL(1'b1)) u_cs (
        .clk(clk), .rst_n(rst_n), .d_i(cs_n),
        .level_o(cs_lvl), .rise_o(cs_rise), .fall_o(cs_fall));

    svc_sync_edge #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sck (
        .clk(clk), .rst_n(rst_n), .d_i(sclk),
        .level_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall));

    svc_sync_edge #(.STAGES(SYNC), .RST_VAL(1'b0)) u_sd (
        .clk(clk), .rst_n(rst_n), .d_i(sdata_in),
        .level_o(sd_lvl), .rise_o(sd_rise), .fall_o(sd_fall));

    assign unused_sync = ^{cs_rise, cs_fall, sck_lvl, sd_rise, sd_fall, test_q};

    svc_frame_fsm #(.DW(DW), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .sd_bit(sd_lvl),
        .rd_data(rd_data), .rd_req(rd_req), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sdo(sdata_out), .sdo_oe(sdata_oe));

    svc_regfile #(.DW(DW), .AW(AW), .REF_RST(REF_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .set_left(ovl_left_set), .set_right(ovl_right_set),
        .rd_data(rd_data), .gain_l(gain_left), .gain_r(gain_right),
        .ref_q(peak_ref), .test_q(test_q),
        .gain_l_wr(gain_left_wr), .gain_r_wr(gain_right_wr),
        .stat_rd(status_rd));

    assign mute_oe  = test_q[MOE_BIT];
    assign mute_sel = test_q[MSEL_LSB +: MSEL_W];
endmodule

// File: rtl/svc_regport_chk.sv
module svc_regport_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          sdo,
    input logic          sdo_oe,
    input logic [DW-1:0] gain_l,
    input logic [DW-1:0] gain_r,
    input logic [DW-1:0] peak_ref,
    input logic          gain_l_wr,
    input logic          gain_r_wr,
    input logic          status_rd,
    input logic          wr_en,
    input logic          sck_fall
);
    AST_OE_RELEASED_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3) |-> !sdo_oe); // R5

    AST_GAIN_L_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_l) |-> gain_l_wr); // R8

    AST_GAIN_R_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gain_r) |-> gain_r_wr); // R8

    AST_REF_MOVES_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(peak_ref) |-> $past(wr_en)); // R2

    AST_STROBE_NEEDS_FULL_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_l_wr || gain_r_wr) |-> $past(wr_en)); // R9

    AST_STATUS_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> !status_rd); // R7

    AST_SDO_CHANGES_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> $past(sck_fall)); // R4
endmodule

bind svc_regport svc_regport_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .sdo(sdata_out), .sdo_oe(sdata_oe),
    .gain_l(gain_left), .gain_r(gain_right), .peak_ref(peak_ref),
    .gain_l_wr(gain_left_wr), .gain_r_wr(gain_right_wr),
    .status_rd(status_rd), .wr_en(wr_en), .sck_fall(sck_fall));

// File: tb/svc_regport_tb.sv
module svc_regport_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdata_in = 1'b0;
    logic       ovl_l = 1'b0;
    logic       ovl_r = 1'b0;
    logic       sdata_out, sdata_oe;
    logic [7:0] gain_left, gain_right, peak_ref;
    logic       gain_left_wr, gain_right_wr, status_rd, mute_oe;
    logic [2:0] mute_sel;

    int n_chk = 0;
    int n_err = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    svc_regport dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .ovl_left_set(ovl_l), .ovl_right_set(ovl_r),
        .gain_left(gain_left), .gain_right(gain_right),
        .gain_left_wr(gain_left_wr), .gain_right_wr(gain_right_wr),
        .peak_ref(peak_ref), .status_rd(status_rd),
        .mute_oe(mute_oe), .mute_sel(mute_sel));

    // strobe and pulse monitors
    int l_cnt = 0, r_cnt = 0, both_cnt = 0, st_cnt = 0, max_run = 0, run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (gain_left_wr) l_cnt++;
            if (gain_right_wr) r_cnt++;
            if (gain_left_wr && gain_right_wr) both_cnt++;
            if (status_rd) st_cnt++;
            if (gain_left_wr || gain_right_wr || status_rd) run++;
            else run = 0;
            if (run > max_run) max_run = run;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [7:0] rx_q;
    int oe_bad, edge_bad;

    task automatic xfer(input logic [7:0] ab, input logic [7:0] db, input int nbits);
        logic pre, post, rd;
        rd = ab[2];
        oe_bad = 0;
        edge_bad = 0;
        rx_q = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            sdata_in = (i < 8) ? ab[7-i] : ((i < 16) ? db[15-i] : 1'b1);
            repeat (8) @(negedge clk);
            pre = sdata_out;
            if (sdata_oe !== (rd && i >= 8 && i < 16)) oe_bad++;
            if (rd && i >= 8 && i < 16) rx_q[15-i] = pre;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            post = sdata_out;
            if (rd && i >= 8 && i < 16 && post !== pre) edge_bad++;
            repeat (4) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    function automatic logic [7:0] abyte(input logic [3:0] a, input logic rd);
        return {1'b1, a, rd, 2'b11};
    endfunction

    // {addr, read, write data, expected read data}
    localparam int NV = 21;
    localparam logic [20:0] VEC [NV] = '{
        {4'hD, 1'b1, 8'h00, 8'h00},  // R6 left gain reset
        {4'hE, 1'b1, 8'h00, 8'h00},  // R6 right gain reset
        {4'hC, 1'b1, 8'h00, 8'hFF},  // R6 reference reset
        {4'hA, 1'b1, 8'h00, 8'h00},  // R6 test reset
        {4'hB, 1'b1, 8'h00, 8'h00},  // R6 status reset
        {4'hD, 1'b0, 8'h5A, 8'h00},  // R2
        {4'hE, 1'b0, 8'hC3, 8'h00},  // R2
        {4'hC, 1'b0, 8'h81, 8'h00},  // R2
        {4'hD, 1'b1, 8'h00, 8'h5A},  // R2 R1
        {4'hE, 1'b1, 8'h00, 8'hC3},  // R2
        {4'hC, 1'b1, 8'h00, 8'h81},  // R2
        {4'hF, 1'b0, 8'hE0, 8'h00},  // R3
        {4'hD, 1'b1, 8'h00, 8'hE0},  // R3
        {4'hE, 1'b1, 8'h00, 8'hE0},  // R3
        {4'hF, 1'b1, 8'h00, 8'h00},  // R3 alias reads zero
        {4'hB, 1'b0, 8'hFF, 8'h00},  // R11 status write ignored
        {4'hB, 1'b1, 8'h00, 8'h00},  // R11
        {4'h3, 1'b0, 8'h77, 8'h00},  // R11 unassigned write
        {4'h3, 1'b1, 8'h00, 8'h00},  // R11 unassigned read
        {4'hA, 1'b0, 8'h1E, 8'h00},  // R10
        {4'hA, 1'b1, 8'h00, 8'h1E}   // R10 R2
    };

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int l0, r0, b0, s0;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R6 ports after reset
        chk(gain_left == 8'h00 && gain_right == 8'h00, "R6 gains", {gain_left, gain_right}, 0);
        chk(peak_ref == 8'hFF, "R6 reference", peak_ref, 8'hFF);
        chk(sdata_oe == 1'b0, "R5 idle drive", sdata_oe, 0);

        for (int k = 0; k < NV; k++) begin
            xfer(abyte(VEC[k][20:17], VEC[k][16]), VEC[k][15:8], 16);
            if (VEC[k][16]) chk(rx_q == VEC[k][7:0], $sformatf("R2/R3/R6/R11 entry %0d", k), rx_q, VEC[k][7:0]);
            chk(oe_bad == 0, $sformatf("R4 drive window entry %0d", k), oe_bad, 0);
            chk(edge_bad == 0, $sformatf("R4 bit held over rise entry %0d", k), edge_bad, 0);
        end

        // R10 test register fields
        chk(mute_oe == 1'b1 && mute_sel == 3'd7, "R10 fields 1E", {mute_oe, mute_sel}, 4'hF);
        xfer(abyte(4'hA, 1'b0), 8'h08, 16);
        chk(mute_oe == 1'b0 && mute_sel == 3'd2, "R10 fields 08", {mute_oe, mute_sel}, 4'h2);

        // R1 ignored address bits cleared to zero
        xfer(8'b0_1101_1_00, 8'h00, 16);
        chk(rx_q == 8'hE0, "R1 ignored bits", rx_q, 8'hE0);

        // R3 R8 strobes
        l0 = l_cnt; r0 = r_cnt; b0 = both_cnt;
        xfer(abyte(4'hF, 1'b0), 8'h42, 16);
        chk(both_cnt == b0 + 1 && l_cnt == l0 + 1 && r_cnt == r0 + 1, "R3 paired strobes", both_cnt - b0, 1);
        chk(gain_left == 8'h42 && gain_right == 8'h42, "R8 gain ports", {gain_left, gain_right}, 16'h4242);
        l0 = l_cnt; r0 = r_cnt;
        xfer(abyte(4'hD, 1'b0), 8'h11, 16);
        chk(l_cnt == l0 + 1 && r_cnt == r0, "R8 left strobe only", {l_cnt - l0, r_cnt - r0}, 1 << 0);

        // R9 short frame and long frame
        l0 = l_cnt;
        xfer(abyte(4'hD, 1'b0), 8'hAA, 12);
        chk(gain_left == 8'h11 && l_cnt == l0, "R9 short frame", gain_left, 8'h11);
        xfer(abyte(4'hD, 1'b0), 8'h33, 20);
        xfer(abyte(4'hD, 1'b1), 8'h00, 16);
        chk(rx_q == 8'h33, "R9 extra bits ignored", rx_q, 8'h33);

        // R7 sticky flags cleared by read
        @(negedge clk) ovl_l = 1'b1;
        @(negedge clk) ovl_l = 1'b0;
        repeat (5) @(negedge clk);
        s0 = st_cnt;
        xfer(abyte(4'hB, 1'b1), 8'h00, 16);
        chk(rx_q == 8'h02, "R7 left flag", rx_q, 8'h02);
        chk(st_cnt == s0 + 1, "R8 status pulse", st_cnt - s0, 1);
        xfer(abyte(4'hB, 1'b1), 8'h00, 16);
        chk(rx_q == 8'h00, "R7 cleared by read", rx_q, 8'h00);
        @(negedge clk) ovl_r = 1'b1;
        @(negedge clk) ovl_r = 1'b0;
        @(negedge clk) ovl_l = 1'b1;
        @(negedge clk) ovl_l = 1'b0;
        xfer(abyte(4'hB, 1'b1), 8'h00, 16);
        chk(rx_q == 8'h03, "R7 both flags", rx_q, 8'h03);

        // R5 abort a read mid data byte
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            sclk = 1'b0;
            sdata_in = (i < 8) ? abyte(4'hC, 1'b1)[7-i] : 1'b0;
            repeat (8) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (6) @(negedge clk);
        chk(sdata_oe == 1'b1, "R4 drive during read byte", sdata_oe, 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdata_oe == 1'b0, "R5 release on select high", sdata_oe, 0);

        chk(max_run == 1, "R8 pulse width", max_run, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule